// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the floating-point status word and control word that sit next to an execution datapath. Each cycle the datapath may report one exception event: a vector of flag requests, a stack-fault direction, a rounding direction and an internal-error strobe. The unit merges the requests into sticky flags and updates the condition bit that records direction. It raises the error summary, and with it the busy bit and the interrupt request, when any pending flag is not masked. The request stays raised until software issues a clear.

The control word is written through a simple write strobe and holds the six exception masks and the rounding, precision and infinity fields. A combinational output tells the datapath in the same cycle whether the event it is reporting is unmasked. The datapath uses this to decide whether to store a masked default result. The stack-top field of the status word reflects the stack pointer owned by the register stack.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset the control word reads 0x037F (all six exceptions masked, precision field 11). The status word reads 0x0000 with the stack-top input at 0, and the interrupt request is low.
- R2: A control write updates bits 12:8 and 5:0 from the write data in the next cycle. Bit 6 always reads 1, and bits 15:13 and 7 always read 0.
- R3: Event vector bit i (i = 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision) ORs into status bit i one cycle after a valid event. Status bits 5:0 stay set until a clear.
- R4: Event vector bit 6 (stack fault) sets status bit 6 and status bit 0 (invalid), and loads C1 (status bit 9) from the stack-fault direction input, where 1 means overflow.
- R5: A precision event without a stack fault loads C1 from the rounding-direction input, where 1 means rounded up. When both arrive together, the stack-fault direction wins. Any other event leaves C1 unchanged.
- R6: Error summary (bit 7) and busy (bit 15) rise one cycle after a clock edge at which a status flag in 5:0 is set while the registered control word has its mask bit clear. They stay set until a clear, even if the mask is set again. The interrupt request output equals bit 7.
- R7: The internal-error strobe sets status bits 5:0, 7 and 15 in the next cycle whatever the masks are, and leaves bit 6 and C1 unchanged.
- R8: The unmasked output is high in the same cycle when the internal-error strobe is high, or when a valid event requests a flag whose mask bit in the current control word is 0. A stack fault is judged by the invalid mask, bit 0.
- R9: A clear zeroes status bits 7:0 and 15 and keeps C1 and the control word. An event arriving in the same cycle as the clear is recorded on top of the cleared state.
- R10: Status bits 13:11 show the stack-top input in the same cycle. C3, C2 and C0 (bits 14, 10, 8) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_we | input | 1 | Control word write strobe |
| cw_wdata | input | 16 | Control word write data |
| ev_valid | input | 1 | An exception event is reported this cycle |
| ev_vec | input | 7 | Event requests: 5:0 flags, 6 stack fault |
| ev_sf_dir | input | 1 | Stack fault direction, 1 = overflow |
| ev_rnd_up | input | 1 | Precision event direction, 1 = rounded up |
| int_err | input | 1 | Internal error strobe |
| flag_clr | input | 1 | Clear flags, summary and busy |
| stack_top | input | 3 | Current stack pointer |
| status_word | output | 16 | Status word |
| ctrl_word | output | 16 | Control word |
| irq_pending | output | 1 | Exception interrupt request |
| ev_unmasked | output | 1 | Current event is unmasked |

## Verification
The properties assume that no event, clear or internal-error strobe arrives while the internal synchronized reset is still asserted. They also assume that the flags may only fall in a cycle that carries a clear. The bench drives every stimulus on the falling edge, waits several cycles after releasing reset, and raises a clear only through the scenario tasks. This keeps any flag from falling without one. The scenarios cover these orderings: an unmask that follows a pending flag, a clear that coincides with an event, and a stack fault that coincides with a precision event.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NUM_EXC = 6;
  localparam int EV_W    = NUM_EXC + 1;
  localparam int SW_W    = 16;
  localparam int TOP_W   = 3;

  // event vector / status flag positions
  localparam int EXC_INV  = 0;
  localparam int EXC_PREC = 5;
  localparam int EV_SF    = 6;

  // status word field positions
  localparam int SW_SF    = 6;
  localparam int SW_ES    = 7;
  localparam int SW_C0    = 8;
  localparam int SW_C1    = 9;
  localparam int SW_C2    = 10;
  localparam int SW_TOP_L = 11;
  localparam int SW_C3    = 14;
  localparam int SW_BUSY  = 15;

  localparam logic [SW_W-1:0] CW_WR_MASK  = 16'h1F3F;
  localparam logic [SW_W-1:0] CW_ONES     = 16'h0040;
  localparam logic [SW_W-1:0] CW_RST_VAL  = 16'h037F;
endpackage

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
  import fpx_pkg::*;
#(
  parameter logic [SW_W-1:0] RESET_VAL = CW_RST_VAL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SW_W-1:0] wdata,
  output logic [SW_W-1:0] cw_q
);
  logic [SW_W-1:0] cw_next;

  always_comb begin
    cw_next = cw_q;
    if (we) cw_next = (wdata & CW_WR_MASK) | CW_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cw_q <= RESET_VAL;
    else if (we) cw_q <= cw_next;
  end
endmodule

// File: rtl/fpx_event_decode.sv
module fpx_event_decode
  import fpx_pkg::*;
(
  input  logic               ev_valid,
  input  logic [EV_W-1:0]    ev_vec,
  input  logic               ev_sf_dir,
  input  logic               ev_rnd_up,
  input  logic               int_err,
  input  logic [NUM_EXC-1:0] mask,
  output logic [NUM_EXC-1:0] set_flags,
  output logic               set_sf,
  output logic               c1_load,
  output logic               c1_val,
  output logic               unmasked
);
  logic [NUM_EXC-1:0] ev_flags;

  // stack fault folds into the invalid flag
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_req
    if (i == EXC_INV) begin : g_inv
      assign ev_flags[i] = ev_valid & (ev_vec[i] | ev_vec[EV_SF]);
    end else begin : g_oth
      assign ev_flags[i] = ev_valid & ev_vec[i];
    end
    assign set_flags[i] = ev_flags[i] | int_err;
  end

  assign set_sf = ev_valid & ev_vec[EV_SF];

  always_comb begin
    c1_load = 1'b0;
    c1_val  = 1'b0;
    if (ev_valid && ev_vec[EV_SF]) begin
      c1_load = 1'b1;
      c1_val  = ev_sf_dir;
    end else if (ev_valid && ev_vec[EXC_PREC]) begin
      c1_load = 1'b1;
      c1_val  = ev_rnd_up;
    end
  end

  assign unmasked = int_err | (|(ev_flags & ~mask));
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_EXC-1:0] set_flags,
  input  logic               set_sf,
  input  logic               c1_load,
  input  logic               c1_val,
  input  logic               force_es,
  input  logic [NUM_EXC-1:0] mask,
  output logic [NUM_EXC-1:0] flags_q,
  output logic               sf_q,
  output logic               es_q,
  output logic               c1_q
);
  logic [NUM_EXC-1:0] flags_next;
  logic               sf_next;
  logic               es_next;
  logic               c1_next;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_flag
    assign flags_next[i] = (flags_q[i] & ~clr) | set_flags[i];
  end

  always_comb begin
    sf_next = (sf_q & ~clr) | set_sf;
    es_next = (es_q & ~clr) | force_es | (|(flags_next & ~mask));
    c1_next = c1_load ? c1_val : c1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sf_q    <= 1'b0;
      es_q    <= 1'b0;
      c1_q    <= 1'b0;
    end else begin
      flags_q <= flags_next;
      sf_q    <= sf_next;
      es_q    <= es_next;
      if (c1_load) c1_q <= c1_next;
    end
  end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter logic [SW_W-1:0] CW_RESET = CW_RST_VAL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_we,
  input  logic [SW_W-1:0]  cw_wdata,
  input  logic             ev_valid,
  input  logic [EV_W-1:0]  ev_vec,
  input  logic             ev_sf_dir,
  input  logic             ev_rnd_up,
  input  logic             int_err,
  input  logic             flag_clr,
  input  logic [TOP_W-1:0] stack_top,
  output logic [SW_W-1:0]  status_word,
  output logic [SW_W-1:0]  ctrl_word,
  output logic             irq_pending,
  output logic             ev_unmasked
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [NUM_EXC-1:0] set_flags;
  logic               set_sf;
  logic               c1_load;
  logic               c1_val;
  logic [NUM_EXC-1:0] flags_q;
  logic               sf_q;
  logic               es_q;
  logic               c1_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fpx_ctrl_reg #(.RESET_VAL(CW_RESET)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cw_we),
    .wdata (cw_wdata),
    .cw_q  (ctrl_word)
  );

  fpx_event_decode dec_i (
    .ev_valid  (ev_valid),
    .ev_vec    (ev_vec),
    .ev_sf_dir (ev_sf_dir),
    .ev_rnd_up (ev_rnd_up),
    .int_err   (int_err),
    .mask      (ctrl_word[NUM_EXC-1:0]),
    .set_flags (set_flags),
    .set_sf    (set_sf),
    .c1_load   (c1_load),
    .c1_val    (c1_val),
    .unmasked  (ev_unmasked)
  );

  fpx_status_reg stat_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (flag_clr),
    .set_flags (set_flags),
    .set_sf    (set_sf),
    .c1_load   (c1_load),
    .c1_val    (c1_val),
    .force_es  (int_err),
    .mask      (ctrl_word[NUM_EXC-1:0]),
    .flags_q   (flags_q),
    .sf_q      (sf_q),
    .es_q      (es_q),
    .c1_q      (c1_q)
  );

  always_comb begin
    status_word                          = '0;
    status_word[NUM_EXC-1:0]             = flags_q;
    status_word[SW_SF]                   = sf_q;
    status_word[SW_ES]                   = es_q;
    status_word[SW_C1]                   = c1_q;
    status_word[SW_TOP_L+TOP_W-1:SW_TOP_L] = stack_top;
    status_word[SW_BUSY]                 = es_q;
  end

  assign irq_pending = es_q;
endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flag_clr,
  input logic        ev_valid,
  input logic [6:0]  ev_vec,
  input logic        int_err,
  input logic [15:0] status_word,
  input logic [15:0] ctrl_word,
  input logic        irq_pending,
  input logic        ev_unmasked
);
  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((status_word[5:0] & $past(status_word[5:0])) == $past(status_word[5:0])));

  a_r4_stack_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_vec[6]) |=> (status_word[6] && status_word[0]));

  a_r6_busy_follows_es: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[15] == status_word[7]) && (irq_pending == status_word[7]));

  a_r7_internal: assert property (@(posedge clk) disable iff (!rst_n)
    int_err |=> (status_word[5:0] == 6'h3F && status_word[7]));

  a_r8_unmasked_internal: assert property (@(posedge clk) disable iff (!rst_n)
    int_err |-> ev_unmasked);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ev_valid && !int_err) |=> (status_word[7:0] == 8'h00 && !status_word[15]));

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[6] && ctrl_word[15:13] == 3'b000 && !ctrl_word[7]);

  a_r10_cc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[14] && !status_word[10] && !status_word[8]);
endmodule

bind fpx_status_unit fpx_status_unit_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .flag_clr    (flag_clr),
  .ev_valid    (ev_valid),
  .ev_vec      (ev_vec),
  .int_err     (int_err),
  .status_word (status_word),
  .ctrl_word   (ctrl_word),
  .irq_pending (irq_pending),
  .ev_unmasked (ev_unmasked)
);

// File: tb/fpx_status_unit_tb_top.sv
`timescale 1ns/1ps
module fpx_status_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cw_we;
  logic [15:0] cw_wdata;
  logic        ev_valid;
  logic [6:0]  ev_vec;
  logic        ev_sf_dir;
  logic        ev_rnd_up;
  logic        int_err;
  logic        flag_clr;
  logic [2:0]  stack_top;
  logic [15:0] status_word;
  logic [15:0] ctrl_word;
  logic        irq_pending;
  logic        ev_unmasked;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // requirement-level model state
  logic [5:0]  m_flags;
  logic        m_sf, m_es, m_c1;
  logic [15:0] m_cw;

  fpx_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cw_we(cw_we), .cw_wdata(cw_wdata),
    .ev_valid(ev_valid), .ev_vec(ev_vec), .ev_sf_dir(ev_sf_dir),
    .ev_rnd_up(ev_rnd_up), .int_err(int_err), .flag_clr(flag_clr),
    .stack_top(stack_top), .status_word(status_word), .ctrl_word(ctrl_word),
    .irq_pending(irq_pending), .ev_unmasked(ev_unmasked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sw();
    return {m_es, 1'b0, stack_top, 1'b0, m_c1, 1'b0, m_es, m_sf, m_flags};
  endfunction

  task automatic idle_inputs();
    cw_we = 0; cw_wdata = '0; ev_valid = 0; ev_vec = '0;
    ev_sf_dir = 0; ev_rnd_up = 0; int_err = 0; flag_clr = 0;
  endtask

  // one cycle, starting and ending at a falling edge
  task automatic step(input string req, input logic we, input logic [15:0] wd,
                      input logic v, input logic [6:0] e, input logic sfd,
                      input logic rup, input logic ie, input logic cl);
    logic [5:0] eff;
    logic       exp_um;
    cw_we = we; cw_wdata = wd; ev_valid = v; ev_vec = e;
    ev_sf_dir = sfd; ev_rnd_up = rup; int_err = ie; flag_clr = cl;
    #1;
    eff    = v ? (e[5:0] | {5'b0, e[6]}) : 6'b0;
    exp_um = ie | (|(eff & ~m_cw[5:0]));
    chk(req, "ev_unmasked", {15'b0, ev_unmasked}, {15'b0, exp_um});
    @(posedge clk);
    if (cl) begin m_flags = '0; m_sf = 0; m_es = 0; end
    if (v) begin
      m_flags |= e[5:0];
      if (e[6]) begin m_sf = 1; m_flags[0] = 1; m_c1 = sfd; end
      else if (e[5]) m_c1 = rup;
    end
    if (ie) begin m_flags = 6'h3F; m_es = 1; end
    if (|(m_flags & ~m_cw[5:0])) m_es = 1;
    if (we) m_cw = (wd & 16'h1F3F) | 16'h0040;
    @(negedge clk);
    idle_inputs();
    #1;
    chk(req, "status_word", status_word, exp_sw());
    chk(req, "ctrl_word", ctrl_word, m_cw);
    chk(req, "irq_pending", {15'b0, irq_pending}, {15'b0, m_es});
  endtask

  task automatic t_reset();
    idle_inputs();
    stack_top = 3'd0;
    rst_n = 0;
    m_flags = '0; m_sf = 0; m_es = 0; m_c1 = 0; m_cw = 16'h037F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "reset status", status_word, 16'h0000);
    chk("R1", "reset ctrl", ctrl_word, 16'h037F);
    chk("R1", "reset irq", {15'b0, irq_pending}, 16'h0000);
  endtask

  task automatic t_cw_write();   // R2
    step("R2", 1, 16'hFFFF, 0, 7'h00, 0, 0, 0, 0);
    chk("R2", "all ones write", ctrl_word, 16'h1F7F);
    step("R2", 1, 16'h0000, 0, 7'h00, 0, 0, 0, 0);
    chk("R2", "zero write", ctrl_word, 16'h0040);
    step("R2", 1, 16'h037F, 0, 7'h00, 0, 0, 0, 0);
  endtask

  task automatic t_masked_events();   // R3, masked summary R6
    for (int i = 0; i < 6; i++)
      step("R3", 0, 0, 1, 7'(1 << i), 0, 0, 0, 0);
    chk("R3", "all flags, no summary", status_word & 16'h80FF, 16'h003F);
    step("R3", 0, 0, 0, 7'h3F, 0, 0, 0, 0);   // invalid strobe: no change
    step("R9", 0, 0, 0, 7'h00, 0, 0, 0, 1);
  endtask

  task automatic t_stack_fault();   // R4
    step("R4", 0, 0, 1, 7'h40, 1, 0, 0, 0);
    chk("R4", "overflow dir", status_word & 16'h0241, 16'h0241);
    step("R4", 0, 0, 1, 7'h40, 0, 1, 0, 0);
    chk("R4", "underflow dir", status_word & 16'h0200, 16'h0000);
    step("R9", 0, 0, 0, 7'h00, 0, 0, 0, 1);
  endtask

  task automatic t_precision_c1();   // R5
    step("R5", 0, 0, 1, 7'h20, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 7'h08, 0, 0, 0, 0);
    chk("R5", "C1 held on overflow", status_word & 16'h0200, 16'h0200);
    step("R5", 0, 0, 1, 7'h20, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 7'h60, 1, 0, 0, 0);
    chk("R5", "stack fault dir wins", status_word & 16'h0200, 16'h0200);
    step("R9", 0, 0, 0, 7'h00, 0, 0, 0, 1);
  endtask

  task automatic t_unmask_summary();   // R6, R8
    step("R6", 1, 16'h037E, 0, 7'h00, 0, 0, 0, 0);
    step("R8", 0, 0, 1, 7'h04, 0, 0, 0, 0);          // masked zero-divide
    step("R8", 0, 0, 1, 7'h01, 0, 0, 0, 0);          // unmasked invalid
    step("R6", 1, 16'h037F, 0, 7'h00, 0, 0, 0, 0);   // re-mask
    step("R6", 0, 0, 0, 7'h00, 0, 0, 0, 0);
    chk("R6", "summary held", {15'b0, irq_pending}, 16'h0001);
    step("R9", 0, 0, 0, 7'h00, 0, 0, 0, 1);
    step("R6", 0, 0, 1, 7'h02, 0, 0, 0, 0);          // pending denormal, masked
    step("R6", 1, 16'h037D, 0, 7'h00, 0, 0, 0, 0);   // unmask it
    step("R6", 0, 0, 0, 7'h00, 0, 0, 0, 0);
    chk("R6", "late unmask", status_word & 16'h8080, 16'h8080);
    step("R8", 0, 0, 1, 7'h40, 1, 0, 0, 0);          // stack fault under invalid mask 1
    step("R9", 1, 16'h037F, 0, 7'h00, 0, 0, 0, 1);
  endtask

  task automatic t_internal();   // R7
    step("R7", 0, 0, 1, 7'h20, 0, 1, 0, 0);   // C1 = 1 first
    step("R7", 0, 0, 0, 7'h00, 0, 0, 1, 0);
    chk("R7", "internal error word", status_word & 16'h82FF, 16'h82BF);
    step("R9", 0, 0, 0, 7'h00, 0, 0, 0, 1);
  endtask

  task automatic t_clear();   // R9
    step("R9", 0, 0, 1, 7'h07, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 7'h08, 0, 0, 0, 1);
    chk("R9", "clear then record", status_word & 16'h80FF, 16'h0008);
    step("R9", 1, 16'h0F3B, 0, 7'h00, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 7'h00, 0, 0, 0, 1);
    chk("R9", "ctrl kept", ctrl_word, 16'h0F7B);
    step("R9", 1, 16'h037F, 0, 7'h00, 0, 0, 0, 1);
  endtask

  task automatic t_stack_top();   // R10
    for (int t = 0; t < 8; t += 3) begin
      stack_top = 3'(t);
      #1;
      chk("R10", "stack top field", {13'b0, status_word[13:11]}, 16'(t));
      step("R10", 0, 0, 1, 7'h10, 0, 0, 0, 0);
    end
    stack_top = 3'd0;
  endtask

  initial begin
    t_reset();
    t_cw_write();
    t_masked_events();
    t_stack_fault();
    t_precision_c1();
    t_unmask_summary();
    t_internal();
    t_clear();
    t_stack_top();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule